// File: doc/BRIEF.md
# SPI Master Serial Clock Divider

This block produces the serial clock of an SPI master. It divides the peripheral clock by a ratio chosen through a 7-bit rate code, which is held in a 16-bit register. The serial clock idles low. It toggles only while the block is in master mode and a transfer is active. Next to the clock level, two single-cycle strobes tell the shift logic when to sample (rising edge) and when to shift (falling edge). One data bit moves per serial clock period.

In slave mode the divider stays idle and the rate code has no effect. In that mode the block watches the serial clock arriving from the remote master. It raises an overspeed strobe whenever two rising edges of that clock arrive closer together than four peripheral clocks. A rate change written during a transfer is applied only at the end of the current period, so the clock never produces a clipped pulse.

Top module: `spi_baud_gen`

## Requirements
- R1: While the synchronous active-low reset is asserted, the next clock edge clears the rate code to 0 and drives `regRdData` to 0. It also drives `sclkOut`, `samplePulse`, `shiftPulse` and `overspeedErr` low. The same holds when reset is applied in the middle of a transfer.
- R2: A write stores `regWrData[6:0]` as the rate code. `regRdData[6:0]` returns the stored code. `regRdData[15:7]` always reads 0, and write data in those bits has no effect on any output.
- R3: For codes 3 to 127, one serial clock period lasts code+1 peripheral clock cycles.
- R4: Codes 0, 1 and 2 each give a period of 4 peripheral clock cycles.
- R5: Within each period of length D, the clock is low for floor(D/2) cycles and then high for ceil(D/2) cycles.
- R6: When the transfer-active input is low, `sclkOut` is low from the next cycle on. The first clock edge that samples the input high starts a period with a full low phase.
- R7: A code written during a transfer does not change the current period. The new length applies from the next period boundary onward.
- R8: `samplePulse` is high for exactly the one cycle in which `sclkOut` has just risen. `shiftPulse` is high for exactly the one cycle in which `sclkOut` has just fallen at a period end. The two strobes are never high together.
- R9: With the master-mode input low, `sclkOut`, `samplePulse` and `shiftPulse` stay low whatever the rate code or transfer input.
- R10: In slave mode the external serial clock passes through a two-stage synchronizer. `overspeedErr` pulses for one cycle when two of its rising edges arrive fewer than 4 peripheral clocks apart. Spacing of 4 or more produces no pulse, and master mode never produces one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWrEn | input | 1 | Rate register write strobe |
| regWrData | input | 16 | Rate register write data |
| regRdData | output | 16 | Rate register read data |
| masterMode | input | 1 | 1 = master (divider runs), 0 = slave |
| xferActive | input | 1 | High while a transfer is in progress |
| extSclk | input | 1 | Serial clock from a remote master (slave mode) |
| sclkOut | output | 1 | Generated serial clock, idles low |
| samplePulse | output | 1 | One-cycle strobe at each rising serial clock edge |
| shiftPulse | output | 1 | One-cycle strobe at each falling serial clock edge |
| overspeedErr | output | 1 | One-cycle strobe when the incoming slave clock is too fast |

## Verification
The assertions assume that the master-mode and transfer-active inputs change only between clock edges. They also assume that a transfer ends only by taking the transfer-active input low, which clears the clock at once. The high-phase property relies on both of those inputs staying high across the rising edge it checks. The stimulus changes every input at the falling clock edge, switches mode only while no transfer is running, and drives the external slave clock as a bench-timed waveform, so each of these assumptions holds.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

  parameter int unsigned REG_W   = 16;
  parameter int unsigned RATE_W  = 7;
  parameter int unsigned DIV_W   = RATE_W + 1;
  parameter int unsigned MIN_DIV = 4;
  parameter int unsigned MIN_GAP = 4;

  // Strobes and period geometry handed from control to datapath
  typedef struct packed {
    logic             clear;    // divider held idle
    logic             start;    // first cycle of a transfer
    logic             advance;  // divider running
    logic [DIV_W-1:0] divLen;   // active period length
    logic [DIV_W-1:0] lowLen;   // low-phase length
  } dpStrobes_t;

endpackage

// File: rtl/spi_baud_ctrl.sv
module spi_baud_ctrl
  import spi_baud_pkg::*;
#(
  parameter int unsigned P_REG_W   = REG_W,
  parameter int unsigned P_RATE_W  = RATE_W,
  parameter int unsigned P_DIV_W   = DIV_W,
  parameter int unsigned P_MIN_DIV = MIN_DIV
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [P_REG_W-1:0] regWrData,
  output logic [P_REG_W-1:0] regRdData,
  input  logic               masterMode,
  input  logic               xferActive,
  input  logic               periodEnd,
  output dpStrobes_t         strobes
);

  localparam logic [P_RATE_W-1:0] CLAMP_LIMIT = P_RATE_W'(P_MIN_DIV - 1);

  logic [P_RATE_W-1:0] rateReg;
  logic [P_DIV_W-1:0]  activeDiv;
  logic [P_DIV_W-1:0]  reqDiv;
  logic                running;
  logic                runReq;
  logic                unusedHiBits;

  assign unusedHiBits = ^regWrData[P_REG_W-1:P_RATE_W];
  assign runReq       = masterMode & xferActive;

  // Small codes collapse to the minimum divisor
  always_comb begin
    if (rateReg < CLAMP_LIMIT) reqDiv = P_DIV_W'(P_MIN_DIV);
    else                       reqDiv = P_DIV_W'(rateReg) + P_DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateReg   <= '0;
      activeDiv <= P_DIV_W'(P_MIN_DIV);
      running   <= 1'b0;
    end else begin
      if (regWrEn) rateReg <= regWrData[P_RATE_W-1:0];
      running <= runReq;
      if ((runReq && !running) || (runReq && running && periodEnd))
        activeDiv <= reqDiv;
    end
  end

  always_comb begin
    strobes.clear   = ~runReq;
    strobes.start   = runReq & ~running;
    strobes.advance = runReq & running;
    strobes.divLen  = activeDiv;
    strobes.lowLen  = activeDiv >> 1;
  end

  assign regRdData = P_REG_W'(rateReg);

endmodule

// File: rtl/spi_baud_dp.sv
module spi_baud_dp
  import spi_baud_pkg::*;
#(
  parameter int unsigned P_DIV_W = DIV_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobes_t strobes,
  output logic       periodEnd,
  output logic       sclkOut,
  output logic       samplePulse,
  output logic       shiftPulse
);

  logic [P_DIV_W-1:0] pos;
  logic [P_DIV_W-1:0] nextPos;

  assign periodEnd = (pos == strobes.divLen - P_DIV_W'(1));

  always_comb begin
    if (strobes.clear || strobes.start) nextPos = '0;
    else if (strobes.advance)           nextPos = periodEnd ? '0 : pos + P_DIV_W'(1);
    else                                nextPos = pos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos         <= '0;
      sclkOut     <= 1'b0;
      samplePulse <= 1'b0;
      shiftPulse  <= 1'b0;
    end else begin
      pos         <= nextPos;
      sclkOut     <= strobes.advance && (nextPos >= strobes.lowLen);
      samplePulse <= strobes.advance && !periodEnd && (nextPos == strobes.lowLen);
      shiftPulse  <= strobes.advance && periodEnd;
    end
  end

endmodule

// File: rtl/spi_baud_slvmon.sv
module spi_baud_slvmon
  import spi_baud_pkg::*;
#(
  parameter int unsigned P_MIN_GAP = MIN_GAP
) (
  input  logic clk,
  input  logic rstN,
  input  logic masterMode,
  input  logic extSclk,
  output logic overspeedErr
);

  localparam int unsigned GAP_W = $clog2(P_MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LIMIT = GAP_W'(P_MIN_GAP);

  logic [2:0]       syncPipe;
  logic             riseDet;
  logic             seenEdge;
  logic [GAP_W-1:0] gapCnt;

  assign riseDet = syncPipe[1] & ~syncPipe[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPipe     <= '0;
      seenEdge     <= 1'b0;
      gapCnt       <= '0;
      overspeedErr <= 1'b0;
    end else begin
      syncPipe <= {syncPipe[1:0], extSclk};
      if (masterMode) begin
        seenEdge     <= 1'b0;
        gapCnt       <= '0;
        overspeedErr <= 1'b0;
      end else begin
        overspeedErr <= riseDet && seenEdge && (gapCnt < GAP_LIMIT);
        if (riseDet) begin
          seenEdge <= 1'b1;
          gapCnt   <= GAP_W'(1);
        end else if (gapCnt < GAP_LIMIT) begin
          gapCnt <= gapCnt + GAP_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        masterMode,
  input  logic        xferActive,
  input  logic        extSclk,
  output logic        sclkOut,
  output logic        samplePulse,
  output logic        shiftPulse,
  output logic        overspeedErr
);

  dpStrobes_t strobes;
  logic       periodEnd;

  spi_baud_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .masterMode(masterMode), .xferActive(xferActive),
    .periodEnd(periodEnd), .strobes(strobes)
  );

  spi_baud_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .periodEnd(periodEnd),
    .sclkOut(sclkOut), .samplePulse(samplePulse), .shiftPulse(shiftPulse)
  );

  spi_baud_slvmon u_slvmon (
    .clk(clk), .rstN(rstN), .masterMode(masterMode),
    .extSclk(extSclk), .overspeedErr(overspeedErr)
  );

endmodule

// File: rtl/spi_baud_chk.sv
module spi_baud_chk (
  input logic        clk,
  input logic        rstN,
  input logic        masterMode,
  input logic        xferActive,
  input logic [15:0] regRdData,
  input logic        sclkOut,
  input logic        samplePulse,
  input logic        shiftPulse,
  input logic        overspeedErr
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[15:7] == 9'd0); // R2

  AST_HIGH_MIN_TWO: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclkOut) && xferActive && masterMode) |=> sclkOut); // R5

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |=> !sclkOut); // R6

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> $rose(sclkOut)); // R8

  AST_RISE_HAS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclkOut) |-> samplePulse); // R8

  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    shiftPulse |-> $fell(sclkOut)); // R8

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(samplePulse && shiftPulse)); // R8

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |=> (!sclkOut && !samplePulse && !shiftPulse)); // R9

  AST_ERR_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $past(masterMode) |-> !overspeedErr); // R10

endmodule

bind spi_baud_gen spi_baud_chk u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .xferActive(xferActive),
  .regRdData(regRdData), .sclkOut(sclkOut), .samplePulse(samplePulse),
  .shiftPulse(shiftPulse), .overspeedErr(overspeedErr)
);

// File: tb/spi_baud_gen_bench.sv
module spi_baud_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        masterMode = 1'b1;
  logic        xferActive = 1'b0;
  logic        extSclk = 1'b0;
  logic        sclkOut, samplePulse, shiftPulse, overspeedErr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  spi_baud_gen u_spi_baud_gen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .masterMode(masterMode), .xferActive(xferActive),
    .extSclk(extSclk), .sclkOut(sclkOut), .samplePulse(samplePulse),
    .shiftPulse(shiftPulse), .overspeedErr(overspeedErr)
  );

  function automatic int expDiv(input int code);
    return (code < 3) ? 4 : code + 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic writeReg(input logic [15:0] data);
    regWrEn = 1'b1; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Compare one cycle of outputs against position p within period d
  function automatic bit cycleOk(input int p, input int d, input int j);
    bit eSclk, eSample, eShift;
    eSclk   = (p >= d / 2);
    eSample = (p == d / 2);
    eShift  = (p == 0) && (j > 0);
    return (sclkOut == eSclk) && (samplePulse == eSample) && (shiftPulse == eShift);
  endfunction

  // Run a transfer; optionally write newCode at cycle d1+1
  task automatic runXfer(input int code, input int nPer, input bit doChange,
                         input int newCode, input string req);
    int d1, d2, total, bad, firstJ;
    d1 = expDiv(code);
    d2 = expDiv(newCode);
    total = doChange ? (2 * d1 + nPer * d2) : nPer * d1;
    bad = 0; firstJ = -1;
    xferActive = 1'b1;
    for (int j = 0; j < total; j++) begin
      @(negedge clk);
      regWrEn = 1'b0;
      if (!doChange || j < 2 * d1) begin
        if (!cycleOk(j % d1, d1, j)) begin bad++; if (firstJ < 0) firstJ = j; end
      end else begin
        if (!cycleOk((j - 2 * d1) % d2, d2, j)) begin bad++; if (firstJ < 0) firstJ = j; end
      end
      if (doChange && j == d1 + 1) begin
        regWrEn = 1'b1; regWrData = 16'(newCode);
      end
    end
    check(bad == 0, req, $sformatf("waveform code=%0d mismatches (first at %0d)", code, firstJ), bad, 0);
    xferActive = 1'b0;
    @(negedge clk);
    check(sclkOut == 1'b0, "R6", "idle level after transfer", int'(sclkOut), 0);
  endtask

  task automatic slaveDrive(input int hi, input int lo, input int edges, output int errCnt);
    errCnt = 0;
    for (int e = 0; e < edges; e++) begin
      extSclk = 1'b1;
      for (int k = 0; k < hi; k++) begin @(negedge clk); if (overspeedErr) errCnt++; end
      extSclk = 1'b0;
      for (int k = 0; k < lo; k++) begin @(negedge clk); if (overspeedErr) errCnt++; end
    end
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (overspeedErr) errCnt++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'h5A17C3));
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check(regRdData == 16'h0, "R1", "rdData in reset", regRdData, 0);
    check({sclkOut, samplePulse, shiftPulse, overspeedErr} == 4'b0, "R1", "outputs in reset",
          {sclkOut, samplePulse, shiftPulse, overspeedErr}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: reserved bits
    writeReg(16'hFFFF);
    check(regRdData == 16'h007F, "R2", "all-ones write read back", regRdData, 16'h007F);
    writeReg(16'hAB85);
    check(regRdData == 16'h0005, "R2", "mixed write read back", regRdData, 16'h0005);
    runXfer(5, 3, 1'b0, 5, "R2");

    // R4: clamped codes
    for (int c = 0; c < 3; c++) begin
      writeReg(16'(c));
      runXfer(c, 3, 1'b0, c, "R4");
    end
    // R3 / R5: directed ends and odd/even divisors
    writeReg(16'd3);   runXfer(3, 3, 1'b0, 3, "R3");
    writeReg(16'd4);   runXfer(4, 3, 1'b0, 4, "R5");
    writeReg(16'd127); runXfer(127, 2, 1'b0, 127, "R3");
    writeReg(16'd126); runXfer(126, 2, 1'b0, 126, "R5");
    // R3 / R5 / R8: random codes
    for (int i = 0; i < 30; i++) begin
      int c;
      c = int'($urandom % 128);
      writeReg(16'(c) | 16'($urandom % 512) << 7);
      runXfer(c, 3, 1'b0, c, "R8");
    end

    // R7: mid-transfer rate change
    writeReg(16'd9);  runXfer(9, 2, 1'b1, 4, "R7");
    writeReg(16'd2);  runXfer(2, 2, 1'b1, 20, "R7");
    writeReg(16'd14); runXfer(14, 2, 1'b1, 7, "R7");

    // R9: slave mode keeps divider quiet
    masterMode = 1'b0;
    writeReg(16'd3);
    xferActive = 1'b1;
    cnt = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (sclkOut || samplePulse || shiftPulse) cnt++;
    end
    check(cnt == 0, "R9", "active cycles in slave mode", cnt, 0);
    xferActive = 1'b0;

    // R10: overspeed detection
    slaveDrive(2, 2, 8, cnt);
    check(cnt == 0, "R10", "errors at gap 4", cnt, 0);
    slaveDrive(3, 5, 6, cnt);
    check(cnt == 0, "R10", "errors at gap 8", cnt, 0);
    slaveDrive(1, 1, 8, cnt);
    check(cnt == 7, "R10", "errors at gap 2", cnt, 7);
    slaveDrive(2, 1, 6, cnt);
    check(cnt == 5, "R10", "errors at gap 3", cnt, 5);
    masterMode = 1'b1;
    @(negedge clk);
    slaveDrive(1, 1, 8, cnt);
    check(cnt == 0, "R10", "errors in master mode", cnt, 0);

    // R1: reset mid-transfer with clock high
    writeReg(16'd9);
    xferActive = 1'b1;
    repeat (7) @(negedge clk);
    check(sclkOut == 1'b1, "R5", "clock high before reset", int'(sclkOut), 1);
    rstN = 1'b0;
    @(negedge clk);
    check(sclkOut == 1'b0 && regRdData == 16'h0, "R1", "clock/register after mid reset",
          {regRdData, 15'd0, sclkOut}, 0);
    rstN = 1'b1;
    xferActive = 1'b0;
    @(negedge clk);
    runXfer(0, 2, 1'b0, 0, "R1");

    summary();
  end

endmodule